// File: doc/BRIEF.md
# Timestamping Sample Packetizer with Holdoff

The block takes single samples from a phase-locked sampling front-end, one possible sample per strobe, and hands them to a buffered back-end as fixed-length frames on a valid/ready stream. Every strobe advances a free-running 32-bit timestamp. The block stamps each frame with the timestamp of its first sample, so a downstream consumer can rebuild arrival order and spot gaps.

Frames are assembled into one of two frame slots. The other slot drains to the output at the same time. When both slots are occupied, the block raises a holdoff toward the front-end. Strobes that occur while holdoff is high are masked. They are not stored, but they still advance the timestamp and are counted. The next frame header reports how many strobes were masked before it. Masking can only begin at a frame boundary, so the samples inside any one frame always carry consecutive timestamps.

A frame on the output is one header word followed by N sample words. In the header word, bits [47:16] are the first-sample timestamp and bits [15:0] are the masked-strobe count. A sample word carries the sample zero-extended in its low bits. The header word is flagged on `m_tuser`. `m_tlast` marks the final sample word.

Top module: `tsp_packetizer`

## Requirements
- R1: While reset is high and in the first cycle after it, `m_tvalid` and `smp_holdoff` are 0. The timestamp restarts at 0, so the first strobe after reset has timestamp 0.
- R2: The timestamp increments by one on every strobe, whether the strobe is masked or accepted. A header's bits [47:16] equal the timestamp of the strobe that delivered the frame's first sample.
- R3: Each frame is one header word with `m_tuser`=1 and `m_tlast`=0, followed by N sample words with `m_tuser`=0. `m_tlast`=1 appears only on the N-th sample word.
- R4: `smp_holdoff` is high in a cycle exactly when two completed frames are held in the frame slots. A frame stops being held at the clock edge that places its final sample word on the output.
- R5: A strobe seen while `smp_holdoff` is high is discarded. Every other strobe's sample appears exactly once on the output, in strobe order, zero-extended. No stored sample is ever overwritten.
- R6: Header bits [15:0] hold the number of masked strobes since the previous frame's first sample, saturating at 65535.
- R7: When the output holds no pending word, the header of a just-completed frame becomes valid no later than two cycles after the cycle of the strobe that completed the frame.
- R8: While `m_tvalid` is high and `m_tready` is low, `m_tvalid`, `m_tdata`, `m_tuser` and `m_tlast` hold their values into the next cycle.
- R9: `smp_holdoff` is never high while a frame is partially filled, so masking happens only at frame boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_strb | input | 1 | Sample opportunity strobe from the front-end |
| smp_data | input | SMP_W | Sample value presented with the strobe |
| smp_holdoff | output | 1 | Sample-enable mask; high means the current strobe is discarded |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Back-end ready |
| m_tdata | output | 48 | Header or sample word |
| m_tuser | output | 1 | High on the header word |
| m_tlast | output | 1 | High on the final sample word of a frame |

## Verification
Two events can share a clock edge. The draining side can free a frame slot on the same edge that the filling side completes a frame into the other slot. A strobe can also arrive in the cycle in which that slot is freed, while holdoff still reflects the full state. Both situations are provoked by running strobes at full rate against an always-ready output, which outpaces the header overhead, and then by random strobe and ready patterns. A behavioural model in the bench tracks held frames only from completions and from the first appearance of each final sample word. Against that model, it judges the holdoff in every cycle and compares each handshaken word, including the gap count that such a collision produces. A long stall with strobes on every cycle drives the gap count into saturation.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  parameter int TS_W  = 32;
  parameter int GAP_W = 16;
  localparam int OUT_W = TS_W + GAP_W;

  typedef struct packed {
    logic [TS_W-1:0]  ts;
    logic [GAP_W-1:0] gap;
  } hdr_t;
endpackage

// File: rtl/tsp_capture.sv
module tsp_capture
  import tsp_pkg::*;
#(
  parameter int N_SMP = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     strb,
  input  logic                     bank_busy,
  output logic                     holdoff,
  output logic                     wr_en,
  output logic                     wr_bank,
  output logic [$clog2(N_SMP)-1:0] wr_idx,
  output logic                     hdr_we,
  output hdr_t                     hdr_out,
  output logic                     frame_done
);
  localparam int IDX_W = $clog2(N_SMP);

  logic [TS_W-1:0]  ts_q;
  logic [GAP_W-1:0] gap_q;
  logic             wbank_q;
  logic [IDX_W-1:0] widx_q;
  logic             accept;

  assign holdoff    = bank_busy;
  assign accept     = strb & ~bank_busy;
  assign wr_en      = accept;
  assign wr_bank    = wbank_q;
  assign wr_idx     = widx_q;
  assign hdr_we     = accept && (widx_q == '0);
  assign hdr_out    = '{ts: ts_q, gap: gap_q};
  assign frame_done = accept && (widx_q == IDX_W'(N_SMP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q    <= '0;
      gap_q   <= '0;
      wbank_q <= 1'b0;
      widx_q  <= '0;
    end else begin
      if (strb) ts_q <= ts_q + 1'b1;
      if (strb && bank_busy) begin
        if (gap_q != '1) gap_q <= gap_q + 1'b1;
      end else if (hdr_we) begin
        gap_q <= '0;
      end
      if (accept) begin
        if (frame_done) begin
          widx_q  <= '0;
          wbank_q <= ~wbank_q;
        end else begin
          widx_q <= widx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsp_frame_store.sv
module tsp_frame_store
  import tsp_pkg::*;
#(
  parameter int N_SMP = 8,
  parameter int SMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [$clog2(N_SMP)-1:0] wr_idx,
  input  logic [SMP_W-1:0]         wr_data,
  input  logic                     hdr_we,
  input  hdr_t                     hdr_in,
  input  logic                     set_full,
  input  logic                     rd_bank,
  input  logic [$clog2(N_SMP)-1:0] rd_idx,
  input  logic                     clr_full,
  output logic [SMP_W-1:0]         rd_data,
  output hdr_t                     rd_hdr,
  output logic                     full_w,
  output logic                     full_r
);
  localparam int ADDR_W = $clog2(2 * N_SMP);
  localparam int NBANK  = 2;

  logic [SMP_W-1:0]  mem [2 * N_SMP];
  hdr_t              hdr_q [NBANK];
  logic [NBANK-1:0]  full_q;
  logic [ADDR_W-1:0] wr_addr, rd_addr;

  assign wr_addr = ADDR_W'(wr_bank) * ADDR_W'(N_SMP) + ADDR_W'(wr_idx);
  assign rd_addr = ADDR_W'(rd_bank) * ADDR_W'(N_SMP) + ADDR_W'(rd_idx);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
  assign rd_hdr  = hdr_q[rd_bank];
  assign full_w  = full_q[wr_bank];
  assign full_r  = full_q[rd_bank];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[b] <= 1'b0;
        hdr_q[b]  <= '0;
      end else begin
        if (hdr_we && wr_bank == 1'(b)) hdr_q[b] <= hdr_in;
        if (set_full && wr_bank == 1'(b)) full_q[b] <= 1'b1;
        else if (clr_full && rd_bank == 1'(b)) full_q[b] <= 1'b0;
      end
    end
  end

  // R5: the writer never lands a sample in a slot still owned by the drain side
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full_q[wr_bank]);
endmodule

// File: rtl/tsp_emitter.sv
module tsp_emitter
  import tsp_pkg::*;
#(
  parameter int N_SMP = 8,
  parameter int SMP_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bank_full,
  input  hdr_t                     hdr,
  input  logic [SMP_W-1:0]         rd_data,
  output logic                     rd_bank,
  output logic [$clog2(N_SMP)-1:0] rd_idx,
  output logic                     release_bank,
  output logic                     m_tvalid,
  input  logic                     m_tready,
  output logic [OUT_W-1:0]         m_tdata,
  output logic                     m_tuser,
  output logic                     m_tlast
);
  localparam int IDX_W  = $clog2(N_SMP);
  localparam int BEAT_W = $clog2(N_SMP + 1);

  logic              rbank_q;
  logic [BEAT_W-1:0] beat_q;
  logic              load;

  assign load         = bank_full && (!m_tvalid || m_tready);
  assign rd_bank      = rbank_q;
  assign rd_idx       = IDX_W'(beat_q - 1'b1);
  assign release_bank = load && (beat_q == BEAT_W'(N_SMP));

  always_ff @(posedge clk) begin
    if (rst) begin
      rbank_q  <= 1'b0;
      beat_q   <= '0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tuser  <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (load) begin
      m_tvalid <= 1'b1;
      if (beat_q == '0) begin
        m_tdata <= {hdr.ts, hdr.gap};
        m_tuser <= 1'b1;
        m_tlast <= 1'b0;
      end else begin
        m_tdata <= OUT_W'(rd_data);
        m_tuser <= 1'b0;
        m_tlast <= (beat_q == BEAT_W'(N_SMP));
      end
      if (release_bank) begin
        beat_q  <= '0;
        rbank_q <= ~rbank_q;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end else if (m_tready) begin
      m_tvalid <= 1'b0;
    end
  end

  // R8: a stalled word stays put
  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast)));
  // R3: the header word never closes a frame
  a_r3_header_not_last: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> !(m_tuser && m_tlast));
endmodule

// File: rtl/tsp_packetizer.sv
module tsp_packetizer
  import tsp_pkg::*;
#(
  parameter int N_SMP = 8,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_strb,
  input  logic [SMP_W-1:0] smp_data,
  output logic             smp_holdoff,
  output logic             m_tvalid,
  input  logic             m_tready,
  output logic [OUT_W-1:0] m_tdata,
  output logic             m_tuser,
  output logic             m_tlast
);
  localparam int IDX_W = $clog2(N_SMP);

  logic             wr_en, wr_bank, hdr_we, frame_done, full_w, full_r;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             rd_bank, release_bank;
  hdr_t             hdr_cap, hdr_rd;
  logic [SMP_W-1:0] rd_data;

  tsp_capture #(.N_SMP(N_SMP)) u_cap (
    .clk(clk), .rst(rst), .strb(smp_strb), .bank_busy(full_w),
    .holdoff(smp_holdoff), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .hdr_we(hdr_we), .hdr_out(hdr_cap), .frame_done(frame_done)
  );

  tsp_frame_store #(.N_SMP(N_SMP), .SMP_W(SMP_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_data(smp_data), .hdr_we(hdr_we), .hdr_in(hdr_cap), .set_full(frame_done),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .clr_full(release_bank),
    .rd_data(rd_data), .rd_hdr(hdr_rd), .full_w(full_w), .full_r(full_r)
  );

  tsp_emitter #(.N_SMP(N_SMP), .SMP_W(SMP_W)) u_emit (
    .clk(clk), .rst(rst), .bank_full(full_r), .hdr(hdr_rd), .rd_data(rd_data),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .release_bank(release_bank),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  // R9: masking only ever begins on a frame boundary
  a_r9_mask_at_boundary: assert property (@(posedge clk) disable iff (rst)
    smp_holdoff |-> (wr_idx == '0));
  // R1: reset leaves the outputs idle in the following cycle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!m_tvalid && !smp_holdoff));
endmodule

// File: tb/tb_tsp_packetizer.sv
module tb_tsp_packetizer;
  localparam int N  = 8;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_strb = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          m_tready = 1'b0;
  logic          smp_holdoff, m_tvalid, m_tuser, m_tlast;
  logic [47:0]   m_tdata;

  always #5 clk = ~clk;

  tsp_packetizer #(.N_SMP(N), .SMP_W(SW)) dut (
    .clk(clk), .rst(rst), .smp_strb(smp_strb), .smp_data(smp_data),
    .smp_holdoff(smp_holdoff), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural reference state
  logic [47:0] q_data[$];
  bit          q_user[$];
  bit          q_last[$];
  logic [SW-1:0] f_smp[$];
  int          staged = 0;
  int          fill = 0;
  logic [31:0] m_ts = 0;
  int          m_gap = 0;
  logic [31:0] f_ts;
  int          f_gap;
  bit          pend_done = 0;
  bit          prev_valid = 0, prev_hs = 0, prev_user = 0, prev_last = 0;
  logic [47:0] prev_data = '0;
  bit          wait_hdr = 0;
  int          deadline = 0;
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input bit s, input logic [SW-1:0] d, input bit r);
    bit newbeat, hs;
    @(negedge clk);
    cyc++;
    if (pend_done) staged++;
    pend_done = 0;
    newbeat = m_tvalid && (!prev_valid || prev_hs);
    if (newbeat && m_tlast) staged--;
    if (wait_hdr && newbeat && m_tuser) begin
      chk(cyc <= deadline, "R7 header latency", cyc, deadline);
      wait_hdr = 0;
    end else if (wait_hdr && cyc > deadline) begin
      chk(0, "R7 header latency", cyc, deadline);
      wait_hdr = 0;
    end
    if (prev_valid && !prev_hs)
      chk(m_tvalid && m_tdata == prev_data && m_tuser == prev_user && m_tlast == prev_last,
          "R8 stalled word changed", m_tdata, prev_data);
    chk(smp_holdoff == (staged == 2), "R4 holdoff", smp_holdoff, staged == 2);
    if (smp_holdoff) chk(fill == 0, "R9 holdoff inside frame", fill, 0);

    smp_strb = s;
    smp_data = d;
    m_tready = r;

    hs = m_tvalid && r;
    if (hs) begin
      if (q_data.size() == 0) begin
        chk(0, "R5 unexpected word", m_tdata, 0);
      end else begin
        logic [47:0] ed;
        bit eu, el;
        ed = q_data.pop_front();
        eu = q_user.pop_front();
        el = q_last.pop_front();
        chk(m_tuser == eu && m_tlast == el, "R3 framing flags", {m_tuser, m_tlast}, {eu, el});
        if (eu) begin
          chk(m_tdata[47:16] == ed[47:16], "R2 header timestamp", m_tdata[47:16], ed[47:16]);
          chk(m_tdata[15:0] == ed[15:0], "R6 gap count", m_tdata[15:0], ed[15:0]);
        end else begin
          chk(m_tdata == ed, "R5 sample word", m_tdata, ed);
        end
      end
    end

    if (s) begin
      if (staged == 2) begin
        if (m_gap < 65535) m_gap++;
      end else begin
        if (fill == 0) begin
          f_ts = m_ts;
          f_gap = m_gap;
          m_gap = 0;
        end
        f_smp.push_back(d);
        fill++;
        if (fill == N) begin
          if (q_data.size() == 0 && !(m_tvalid && !r) && !wait_hdr) begin
            wait_hdr = 1;
            deadline = cyc + 2;
          end
          q_data.push_back({f_ts, f_gap[15:0]});
          q_user.push_back(1'b1);
          q_last.push_back(1'b0);
          for (int i = 0; i < N; i++) begin
            q_data.push_back({32'h0, f_smp[i]});
            q_user.push_back(1'b0);
            q_last.push_back(i == N - 1);
          end
          f_smp.delete();
          fill = 0;
          pend_done = 1;
        end
      end
      m_ts++;
    end

    prev_valid = m_tvalid;
    prev_hs = hs;
    prev_data = m_tdata;
    prev_user = m_tuser;
    prev_last = m_tlast;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle during reset
    chk(!m_tvalid && !smp_holdoff, "R1 reset state", {m_tvalid, smp_holdoff}, 0);
    rst = 1'b0;

    // full-rate strobes against an always-ready output: header overhead forces holdoff
    for (int i = 0; i < 120; i++) step(1'b1, SW'(16'h1000 + i), 1'b1);
    // random strobes and ready
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) < 7, SW'($urandom), $urandom_range(0, 9) < 6);
    // long stall with strobes every cycle: gap count saturates (R6)
    for (int i = 0; i < 70000; i++) step(1'b1, SW'(i), 1'b0);
    // recovery with random strobes
    for (int i = 0; i < 300; i++) step($urandom_range(0, 1) == 1, SW'($urandom), 1'b1);
    // drain
    for (int i = 0; i < 60; i++) step(1'b0, '0, 1'b1);
    chk(q_data.size() == 0, "R5 words lost", q_data.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule